// File: doc/BRIEF.md
# Strap-Sampled Shared Pin Controller

This block owns three shared device pins: a clock pad, a data-out pad and a data-in pad. The clock and data-out pads can carry serial-flash SPI signals, two general-purpose I/O lines, or the clock and data lines of an open-drain two-wire EEPROM bus. The data-in pad always feeds the SPI receive path. The block decides, every cycle, what each pad drives, whether it drives at all, and whether its weak pull-down is on.

The data-out pad also serves as a boot strap. While reset is held, that pad floats with its pull-down on. Shortly after reset is released, its level is sampled and kept until the next reset. The kept bit reports the SPI speed grade as a status output: 0 means 30 MHz and 1 means 60 MHz. The same bit decides what the pad does during suspend: it floats if the bit is 1 and is driven low if the bit is 0.

In GPIO mode, each of the two GPIO lines can also raise a sticky rising-edge interrupt flag. Software clears that flag with a write-one-to-clear pulse.

Top module: `strap_pinmux`

## Requirements
- R1: From reset assertion until the strap is captured, the clock pad drives low (pad_oe[0]=1, pad_o[0]=0). Over the same span, the data-out pad is tri-stated (pad_oe[1]=0) with pad_pd[1]=1. Capture happens on the third rising clock edge after rst_n rises: two edges of reset synchronizer and one capture edge.
- R2: At capture, speed_fast takes the synchronized level of pad_i[1]. A value of 1 means the 60 MHz grade and 0 means the 30 MHz grade. The value then holds until the next reset. From capture on, pad_pd[1]=0.
- R3: The data-in pad (index 2) always has pad_pd[2]=1 and pad_oe[2]=0, and spi_miso follows pad_i[2] combinationally.
- R4: In SPI mode (spi_off=0, twi_en=0, no suspend), pad_o[0]=spi_sck and pad_o[1]=spi_mosi, with both pads driven.
- R5: In GPIO mode (spi_off=1, twi_en=0), index 0 is GPIO4 on the clock pad and index 1 is GPIO5 on the data-out pad. For each index, pad_oe=gpio_dir (1 means output) and pad_o=gpio_out. pin_in shows each pad's level two rising edges after it changes.
- R6: When twi_en=1, two-wire mode overrides spi_off. Both pads output 0, and pad_oe[0]=twi_low[0] (SCL) and pad_oe[1]=twi_low[1] (SDA).
- R7: During suspend, in any mode, the data-out pad outputs 0. It is driven (pad_oe[1]=1) if the captured strap is 0 and tri-stated if it is 1. The clock pad is unaffected by suspend.
- R8: A synchronized rising edge on GPIO line i sets gpio_irq[i] on the third rising clock edge after the pad change. This happens only in GPIO mode with gpio_dir[i]=0 and gpio_irq_en[i]=1. Falling edges, disabled lines and other modes never set the flag.
- R9: gpio_irq[i] is sticky. A pulse on irq_clr[i] clears it at the next edge, unless a new edge sets it in the same cycle, in which case the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| suspend | input | 1 | Device suspend indicator |
| spi_off | input | 1 | Configuration bit turning the SPI pads into GPIO4/GPIO5 |
| twi_en | input | 1 | Selects two-wire EEPROM mode |
| spi_sck | input | 1 | SPI clock from the shifting engine |
| spi_mosi | input | 1 | SPI transmit data from the shifting engine |
| spi_miso | output | 1 | SPI receive data to the shifting engine |
| gpio_dir | input | 2 | GPIO direction, 1 means output |
| gpio_out | input | 2 | GPIO output values |
| gpio_irq_en | input | 2 | Per-line rising-edge interrupt enable |
| irq_clr | input | 2 | Write-one-to-clear pulses for gpio_irq |
| twi_low | input | 2 | Two-wire engine request to pull SCL (0) or SDA (1) low |
| pin_in | output | 2 | Synchronized levels of the clock and data-out pads |
| speed_fast | output | 1 | Captured strap: 1 is 60 MHz, 0 is 30 MHz |
| gpio_irq | output | 2 | Sticky rising-edge interrupt flags |
| pad_i | input | 3 | Pad input levels: clock, data-out, data-in |
| pad_o | output | 3 | Pad output values |
| pad_oe | output | 3 | Pad output enables |
| pad_pd | output | 3 | Pad weak pull-down enables |

## Verification
The assertions assume that pad inputs are asynchronous levels that stay put for several cycles. They also assume that irq_clr is a one-cycle pulse and that mode inputs change only between test steps. The bench meets these assumptions by changing every input on the falling clock edge and holding each level for at least three rising edges. It keeps the strap pad steady across the whole reset-release window, so the captured value is known. It also lines up one clear pulse with a pending edge to show that a set in the same cycle wins over the clear.

// File: rtl/strap_pinmux.sv
module strap_pinmux #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       suspend,
  input  logic       spi_off,
  input  logic       twi_en,
  input  logic       spi_sck,
  input  logic       spi_mosi,
  output logic       spi_miso,
  input  logic [1:0] gpio_dir,
  input  logic [1:0] gpio_out,
  input  logic [1:0] gpio_irq_en,
  input  logic [1:0] irq_clr,
  input  logic [1:0] twi_low,
  output logic [1:0] pin_in,
  output logic       speed_fast,
  output logic [1:0] gpio_irq,
  input  logic [2:0] pad_i,
  output logic [2:0] pad_o,
  output logic [2:0] pad_oe,
  output logic [2:0] pad_pd
);
  logic [1:0] rst_q;
  logic       done;
  logic       strap;
  logic       gpio_mode;
  logic [1:0] irq_set;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      done  <= 1'b0;
      strap <= 1'b0;
    end else if (rst_q[1] && !done) begin
      done  <= 1'b1;
      strap <= pin_in[1];
    end

  assign speed_fast = strap;
  assign spi_miso   = pad_i[2];
  assign gpio_mode  = done & spi_off & ~twi_en;

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [SYNC-1:0] sy;
    logic            prev;
    always_ff @(posedge clk) begin
      sy   <= {sy[SYNC-2:0], pad_i[g]};
      prev <= sy[SYNC-1];
    end
    assign pin_in[g]  = sy[SYNC-1];
    assign irq_set[g] = gpio_mode & ~gpio_dir[g] & gpio_irq_en[g] & sy[SYNC-1] & ~prev;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) gpio_irq[g] <= 1'b0;
      else        gpio_irq[g] <= irq_set[g] | (gpio_irq[g] & ~irq_clr[g]);
  end

  always_comb begin
    pad_o  = 3'b000;
    pad_oe = 3'b000;
    pad_pd = 3'b100;
    if (!done) begin
      pad_oe[0] = 1'b1;
      pad_pd[1] = 1'b1;
    end else begin
      if (twi_en) begin
        pad_oe[1:0] = twi_low;
      end else if (spi_off) begin
        pad_o[1:0]  = gpio_out;
        pad_oe[1:0] = gpio_dir;
      end else begin
        pad_o[1:0]  = {spi_mosi, spi_sck};
        pad_oe[1:0] = 2'b11;
      end
      if (suspend) begin
        pad_o[1]  = 1'b0;
        pad_oe[1] = ~strap;
      end
    end
  end
endmodule

module strap_pinmux_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       suspend,
  input logic       twi_en,
  input logic       done,
  input logic       strap,
  input logic [1:0] twi_low,
  input logic [1:0] irq_clr,
  input logic [1:0] irq_set,
  input logic [1:0] gpio_irq,
  input logic [2:0] pad_o,
  input logic [2:0] pad_oe,
  input logic [2:0] pad_pd
);
  a_r1_boot_pads: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (pad_oe[0] && !pad_o[0] && !pad_oe[1] && pad_pd[1]));

  a_r2_strap_held: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && $stable(strap) && !pad_pd[1]));

  a_r6_open_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (done && twi_en && !suspend) |-> (pad_o[1:0] == 2'b00 && pad_oe[1:0] == twi_low));

  a_r7_suspend_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (done && suspend) |-> (!pad_o[1] && pad_oe[1] == !strap));

  for (genvar g = 0; g < 2; g++) begin : g_irq
    a_r8_set_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq_set[g] |=> gpio_irq[g]);
    a_r9_clear_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr[g] && !irq_set[g]) |=> !gpio_irq[g]);
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (gpio_irq[g] && !irq_clr[g]) |=> gpio_irq[g]);
  end
endmodule

bind strap_pinmux strap_pinmux_chk u_chk (
  .clk(clk), .rst_n(rst_n), .suspend(suspend), .twi_en(twi_en),
  .done(done), .strap(strap), .twi_low(twi_low), .irq_clr(irq_clr),
  .irq_set(irq_set), .gpio_irq(gpio_irq), .pad_o(pad_o),
  .pad_oe(pad_oe), .pad_pd(pad_pd)
);

// File: tb/strap_pinmux_bench.sv
module strap_pinmux_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic suspend = 1'b0, spi_off = 1'b0, twi_en = 1'b0;
  logic spi_sck = 1'b0, spi_mosi = 1'b0, spi_miso;
  logic [1:0] gpio_dir = '0, gpio_out = '0, gpio_irq_en = '0, irq_clr = '0, twi_low = '0;
  logic [1:0] pin_in, gpio_irq;
  logic speed_fast;
  logic [2:0] pad_i = '0, pad_o, pad_oe, pad_pd;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  strap_pinmux u_strap_pinmux (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_boot(input logic s);
    @(negedge clk);
    pad_i[1] = s;
    rst_n = 1'b0;
    #1;
    chk("R1 clock pad low in reset", {pad_oe[0], pad_o[0]}, 2'b10);
    chk("R1 strap pad float+pd in reset", {pad_oe[1], pad_pd[1]}, 2'b01);
    step(3);
    rst_n = 1'b1;
    step(2);
    chk("R1 clock pad low before capture", {pad_oe[0], pad_o[0]}, 2'b10);
    chk("R1 strap pad float before capture", {pad_oe[1], pad_pd[1]}, 2'b01);
    step(1);
    chk("R2 speed_fast strap", speed_fast, s);
    chk("R2 pull-down off after capture", pad_pd[1], 1'b0);
    pad_i[1] = ~s;
    step(4);
    chk("R2 strap held", speed_fast, s);
  endtask

  task automatic t_datain;
    pad_i[2] = 1'b1; #1;
    chk("R3 miso high", spi_miso, 1'b1);
    chk("R3 data-in pad pd on, oe off", {pad_pd[2], pad_oe[2]}, 2'b10);
    pad_i[2] = 1'b0; #1;
    chk("R3 miso low", spi_miso, 1'b0);
  endtask

  task automatic t_spi;
    spi_off = 0; twi_en = 0; suspend = 0;
    spi_sck = 1; spi_mosi = 0; #1;
    chk("R4 spi pads a", {pad_oe[1:0], pad_o[1:0]}, 4'b1101);
    spi_sck = 0; spi_mosi = 1; #1;
    chk("R4 spi pads b", {pad_oe[1:0], pad_o[1:0]}, 4'b1110);
  endtask

  task automatic t_gpio;
    spi_off = 1; gpio_dir = 2'b10; gpio_out = 2'b11; #1;
    chk("R5 gpio pads", {pad_oe[1:0], pad_o[1:0]}, 4'b1011);
    gpio_dir = 2'b01; gpio_out = 2'b01; #1;
    chk("R5 gpio pads swap", {pad_oe[1:0], pad_o[1:0]}, 4'b0101);
    @(negedge clk);
    pad_i[0] = 1'b1; pad_i[1] = 1'b0;
    step(1);
    chk("R5 pin_in not yet", pin_in[0], 1'b0);
    step(1);
    chk("R5 pin_in synced", pin_in, 2'b01);
    pad_i[0] = 1'b0;
    step(2);
    spi_off = 0; gpio_dir = 0; gpio_out = 0;
  endtask

  task automatic t_twi;
    twi_en = 1; spi_off = 1; gpio_dir = 2'b11; gpio_out = 2'b11;
    twi_low = 2'b01; #1;
    chk("R6 scl low request", {pad_oe[1:0], pad_o[1:0]}, 4'b0100);
    twi_low = 2'b10; #1;
    chk("R6 sda low request", {pad_oe[1:0], pad_o[1:0]}, 4'b1000);
    twi_en = 0; spi_off = 0; gpio_dir = 0; gpio_out = 0; twi_low = 0;
  endtask

  task automatic t_suspend(input logic s);
    spi_sck = 1; spi_mosi = 1; suspend = 1; #1;
    chk("R7 suspend data-out pad", {pad_oe[1], pad_o[1]}, {~s, 1'b0});
    chk("R7 clock pad unaffected", {pad_oe[0], pad_o[0]}, 2'b11);
    spi_off = 1; gpio_dir = 2'b11; gpio_out = 2'b11; #1;
    chk("R7 suspend in gpio mode", {pad_oe[1], pad_o[1]}, {~s, 1'b0});
    suspend = 0; spi_off = 0; gpio_dir = 0; gpio_out = 0; spi_sck = 0; spi_mosi = 0;
  endtask

  task automatic t_irq;
    @(negedge clk);
    pad_i[1:0] = 2'b00;
    spi_off = 1; gpio_dir = 2'b00; gpio_irq_en = 2'b01;
    step(4);
    chk("R8 no flag at idle", gpio_irq, 2'b00);
    pad_i[0] = 1'b1; pad_i[1] = 1'b1;
    step(2);
    chk("R8 flag not yet", gpio_irq, 2'b00);
    step(1);
    chk("R8 flag set, disabled line clear", gpio_irq, 2'b01);
    pad_i[0] = 1'b0;
    step(4);
    chk("R9 sticky through falling edge", gpio_irq, 2'b01);
    irq_clr = 2'b01;
    step(1);
    irq_clr = 2'b00;
    chk("R9 cleared", gpio_irq, 2'b00);
    pad_i[0] = 1'b1;
    step(2);
    irq_clr = 2'b01;
    step(1);
    irq_clr = 2'b00;
    chk("R9 set wins over clear", gpio_irq, 2'b01);
    irq_clr = 2'b01; step(1); irq_clr = 2'b00;
    pad_i[0] = 1'b0; step(3);
    spi_off = 0;
    pad_i[0] = 1'b1;
    step(4);
    chk("R8 no flag in SPI mode", gpio_irq, 2'b00);
    spi_off = 1; gpio_dir = 2'b01; pad_i[0] = 1'b0; step(3);
    pad_i[0] = 1'b1; step(4);
    chk("R8 no flag when output", gpio_irq, 2'b00);
    spi_off = 0; gpio_dir = 0; gpio_irq_en = 0; pad_i[1:0] = 0;
  endtask

  initial begin
    t_boot(1'b0);
    t_datain();
    t_spi();
    t_gpio();
    t_twi();
    t_suspend(1'b0);
    t_irq();
    t_boot(1'b1);
    t_suspend(1'b1);
    t_spi();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule